// File: doc/BRIEF.md
# ECC Fuse Preloader and Strap Voter

This block owns a 1024-byte one-time-programmable shadow array. It has two jobs. During boot it takes data bytes from a simple valid/ready byte port and expands each one into two stored bytes. Each stored byte holds one nibble in its low half and four parity bits in its high half. The low nibble is always stored first, at the given array offset, and the high nibble follows at the next offset. Firmware uses this path to plant configuration words, such as a disabled-modules word at array offset 64.

Its second job is to produce a 32-bit strap word continuously. The first twelve array bytes hold three redundant copies of that word. The block settles each output bit by a two-of-three vote across the copies. The strap output has no write path, so it can only change when stored bytes change. A registered read port exposes any array byte for inspection.

A byte whose two stored locations would run past the end of the array is refused. The array is left untouched and a one-cycle error pulse is raised.

Top module: `otp_fuse_preloader`

## Requirements
- R1: After synchronous active-low reset, wr_ready is 1, wr_err is 0, strap_word is 0 and every array byte reads 0.
- R2: A stored byte for nibble d holds d[3:0] in bits 3:0, with bit4 = d0^d1, bit5 = d2^d3, bit6 = d0^d2 and bit7 = d1^d3.
- R3: An accepted byte at offset k stores its encoded low nibble at array byte k and its encoded high nibble at array byte k+1.
- R4: A byte is accepted on a clock edge where wr_valid and wr_ready are both 1. After an in-range acceptance, wr_ready is 0 for exactly two cycles, one per stored byte, and then returns to 1.
- R5: A byte whose offset is above 1022 is dropped. The array is left unchanged, wr_ready stays 1, and wr_err is 1 for exactly the one cycle after that edge.
- R6: strap_word is the bitwise majority of three 32-bit copies held in array bytes 0-3, 4-7 and 8-11. Each copy is little-endian, so its lowest-addressed byte supplies bits 7:0.
- R7: A stored byte shows up in strap_word one cycle after its commit. So just after both bytes of one input have landed, strap_word reflects only the first of them.
- R8: strap_word has no write path. Storing into array bytes outside 0-11 leaves it unchanged.
- R9: rd_data returns the array byte at rd_addr one cycle after rd_addr is applied.
- R10: A 32-bit word fed as four bytes, lowest first, at offsets 64, 66, 68 and 70 fills array bytes 64 to 71 with the eight encoded nibbles in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Byte write request |
| wr_ready | output | 1 | Preloader can take a byte |
| wr_offset | input | 10 | Array byte offset for the low-nibble byte |
| wr_data | input | 8 | Data byte to expand and store |
| wr_err | output | 1 | One-cycle pulse for a dropped out-of-range byte |
| rd_addr | input | 10 | Array byte to inspect |
| rd_data | output | 8 | Registered content of the inspected byte |
| strap_word | output | 32 | Majority-voted strap value |

## Verification
The preload path and the strap vote meet whenever a stored byte lands inside bytes 0 to 11. The vote is then recomputed in the same cycle that the second nibble of the same input is being committed. The bench provokes this by aiming many directed and random bytes at that region, including offsets that straddle two copies. It samples strap_word right after the second commit, where only the first nibble may be visible, and again one cycle later, where the bench's own vote over its model of the array must match.

// File: rtl/otp_fuse_pkg.sv
// Package: shared types and the nibble parity code of the fuse preloader.
// Assumes: callers encode one nibble at a time.
package otp_fuse_pkg;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_LO   = 2'd1,
        LD_HI   = 2'd2
    } ld_state_e;

    // R2: nibble in bits 3:0, four pairwise parity bits above it
    function automatic logic [7:0] nib_encode(input logic [3:0] n);
        logic [3:0] par;
        par[0] = n[0] ^ n[1];
        par[1] = n[2] ^ n[3];
        par[2] = n[0] ^ n[2];
        par[3] = n[1] ^ n[3];
        return {par, n};
    endfunction

endpackage

// File: rtl/otp_nibble_enc.sv
// Module: otp_nibble_enc
// Turns one data nibble into one stored byte with parity.
// Assumes: purely combinational; the caller registers the result.
module otp_nibble_enc
    import otp_fuse_pkg::*;
(
    input  logic [3:0] nib,
    output logic [7:0] code
);

    // Apply the shared parity code
    always_comb begin
        code = nib_encode(nib);
    end

endmodule

// File: rtl/otp_preload_ctrl.sv
// Module: otp_preload_ctrl
// Accepts one byte at a time and sequences its two stored-byte commits.
// It refuses offsets whose second byte would fall past the array.
// Assumes: ARRAY_BYTES is a power of two and at least 2.
module otp_preload_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int ARRAY_BYTES = 1024,
    localparam int ADDR_W     = $clog2(ARRAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_offset,
    input  logic [7:0]        wr_data,
    output logic              wr_ready,
    output logic              wr_err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_hi,
    output logic [7:0]        data_q
);

    localparam logic [ADDR_W:0] LAST_OK = (ADDR_W+1)'(ARRAY_BYTES - 2);

    ld_state_e         state_q;
    logic [ADDR_W-1:0] off_q;
    logic              err_q;
    logic              bad_off;

    // Detect an offset whose high-nibble byte would not fit
    always_comb begin
        bad_off = {1'b0, wr_offset} > LAST_OK;
    end

    // Sequence acceptance, low commit and high commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            off_q   <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                LD_IDLE: begin
                    if (wr_valid) begin
                        if (bad_off) begin
                            err_q <= 1'b1;
                        end else begin
                            off_q   <= wr_offset;
                            data_q  <= wr_data;
                            state_q <= LD_LO;
                        end
                    end
                end
                LD_LO:   state_q <= LD_HI;
                LD_HI:   state_q <= LD_IDLE;
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    // Drive the handshake and the array write strobe
    always_comb begin
        wr_ready   = (state_q == LD_IDLE);
        wr_err     = err_q;
        mem_we     = (state_q != LD_IDLE);
        mem_sel_hi = (state_q == LD_HI);
        mem_addr   = mem_sel_hi ? off_q + ADDR_W'(1) : off_q;
    end

endmodule

// File: rtl/otp_cell_store.sv
// Module: otp_cell_store
// Register-based shadow of the fuse array: one write port, one registered
// read port, and a flat view of the first HEAD_BYTES bytes for the voter.
// Assumes: reset clears the shadow to the unprogrammed (all-zero) state.
module otp_cell_store #(
    parameter int ARRAY_BYTES = 1024,
    parameter int HEAD_BYTES  = 12,
    localparam int ADDR_W     = $clog2(ARRAY_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     waddr,
    input  logic [7:0]            wdata,
    input  logic [ADDR_W-1:0]     raddr,
    output logic [7:0]            rdata,
    output logic [8*HEAD_BYTES-1:0] head
);

    logic [7:0] cells [ARRAY_BYTES];

    // Clear on reset, otherwise commit one byte per write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARRAY_BYTES; i++) begin
                cells[i] <= 8'h00;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Register the inspection read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else begin
            rdata <= cells[raddr];
        end
    end

    // Expose the head bytes, lowest address in the lowest bits
    for (genvar g = 0; g < HEAD_BYTES; g++) begin : g_head
        assign head[8*g +: 8] = cells[g];
    end

endmodule

// File: rtl/otp_strap_vote.sv
// Module: otp_strap_vote
// Bitwise majority across COPIES redundant words, registered.
// Assumes: COPIES is odd; copy k sits at bits [k*WORD_W +: WORD_W].
module otp_strap_vote #(
    parameter int WORD_W = 32,
    parameter int COPIES = 3,
    localparam int CNT_W = $clog2(COPIES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [COPIES*WORD_W-1:0] copies,
    output logic [WORD_W-1:0]        strap
);

    localparam logic [CNT_W-1:0] HALF = CNT_W'(COPIES / 2);

    logic [WORD_W-1:0] maj;

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        logic [CNT_W-1:0] ones;
        // Count the copies that hold a one at this bit position
        always_comb begin
            ones = '0;
            for (int k = 0; k < COPIES; k++) begin
                ones = ones + CNT_W'(copies[k*WORD_W + b]);
            end
            maj[b] = ones > HALF;
        end
    end

    // Register the voted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap <= '0;
        end else begin
            strap <= maj;
        end
    end

endmodule

// File: rtl/otp_fuse_preloader.sv
// Module: otp_fuse_preloader (top)
// Expands incoming bytes into parity-coded nibble bytes in the fuse shadow,
// and presents the majority-voted strap word built from its head bytes.
// Assumes: a single writer; strap copies are little-endian.
module otp_fuse_preloader #(
    parameter int ARRAY_BYTES = 1024,
    parameter int WORD_W      = 32,
    parameter int COPIES      = 3,
    localparam int ADDR_W     = $clog2(ARRAY_BYTES),
    localparam int HEAD_BYTES = COPIES * WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_offset,
    input  logic [7:0]        wr_data,
    output logic              wr_err,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [WORD_W-1:0] strap_word
);

    logic                    mem_we;
    logic [ADDR_W-1:0]       mem_addr;
    logic                    mem_sel_hi;
    logic [7:0]              data_q;
    logic [7:0]              nib_code [2];
    logic [7:0]              mem_wdata;
    logic [8*HEAD_BYTES-1:0] head;

    otp_preload_ctrl #(.ARRAY_BYTES(ARRAY_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_offset  (wr_offset),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .wr_err     (wr_err),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_sel_hi (mem_sel_hi),
        .data_q     (data_q)
    );

    // One encoder per nibble of the latched byte
    for (genvar g = 0; g < 2; g++) begin : g_enc
        otp_nibble_enc u_enc (
            .nib  (data_q[4*g +: 4]),
            .code (nib_code[g])
        );
    end

    // R3: low nibble first, high nibble on the following commit
    always_comb begin
        mem_wdata = mem_sel_hi ? nib_code[1] : nib_code[0];
    end

    otp_cell_store #(
        .ARRAY_BYTES (ARRAY_BYTES),
        .HEAD_BYTES  (HEAD_BYTES)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data),
        .head  (head)
    );

    otp_strap_vote #(
        .WORD_W (WORD_W),
        .COPIES (COPIES)
    ) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .copies (head),
        .strap  (strap_word)
    );

endmodule

// File: rtl/otp_fuse_preloader_chk.sv
// Module: otp_fuse_preloader_chk
// Port-level protocol and timing properties of the fuse preloader.
// Assumes: bound to every instance of otp_fuse_preloader.
module otp_fuse_preloader_chk #(
    parameter int ARRAY_BYTES = 1024,
    parameter int WORD_W      = 32,
    localparam int ADDR_W     = $clog2(ARRAY_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_offset,
    input logic              wr_err,
    input logic [WORD_W-1:0] strap_word
);

    logic bad;

    // Classify the presented offset from the ports alone
    always_comb begin
        bad = int'(wr_offset) > ARRAY_BYTES - 2;
    end

    p_busy_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !bad) |=> !wr_ready ##1 !wr_ready ##1 wr_ready);

    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_valid && wr_ready && bad));

    p_err_keeps_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> wr_ready);

    p_strap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_ready, 2) |-> $stable(strap_word));

endmodule

bind otp_fuse_preloader otp_fuse_preloader_chk #(
    .ARRAY_BYTES (ARRAY_BYTES),
    .WORD_W      (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_offset  (wr_offset),
    .wr_err     (wr_err),
    .strap_word (strap_word)
);

// File: tb/otp_fuse_preloader_bench.sv
// Bench: otp_fuse_preloader_bench
// Seeded random and directed writes checked against a byte model of the array.
module otp_fuse_preloader_bench;

    localparam int AB = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid;
    logic        wr_ready;
    logic [9:0]  wr_offset;
    logic [7:0]  wr_data;
    logic        wr_err;
    logic [9:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [31:0] strap_word;

    logic [7:0]  model [AB];
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #5 clk = ~clk;

    otp_fuse_preloader u_otp_fuse_preloader (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_offset  (wr_offset),
        .wr_data    (wr_data),
        .wr_err     (wr_err),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .strap_word (strap_word)
    );

    function automatic logic [7:0] enc(input logic [3:0] n);
        return {n[1] ^ n[3], n[0] ^ n[2], n[2] ^ n[3], n[0] ^ n[1], n};
    endfunction

    function automatic logic [31:0] vote();
        logic [31:0] w [3];
        for (int k = 0; k < 3; k++)
            w[k] = {model[4*k+3], model[4*k+2], model[4*k+1], model[4*k]};
        return (w[0] & w[1]) | (w[0] & w[2]) | (w[1] & w[2]);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Present one byte at a negedge and follow its handshake to completion
    task automatic send(input int off, input logic [7:0] d);
        logic [31:0] lo_vote;
        wr_valid  = 1'b1;
        wr_offset = off[9:0];
        wr_data   = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        if (off > AB - 2) begin
            chk(wr_err == 1'b1, "R5 err pulse", {31'd0, wr_err}, 32'd1);
            chk(wr_ready == 1'b1, "R5 ready kept", {31'd0, wr_ready}, 32'd1);
            @(negedge clk);
            chk(wr_err == 1'b0, "R5 pulse width", {31'd0, wr_err}, 32'd0);
        end else begin
            chk(wr_ready == 1'b0, "R4 busy1", {31'd0, wr_ready}, 32'd0);
            chk(wr_err == 1'b0, "R5 no err", {31'd0, wr_err}, 32'd0);
            model[off] = enc(d[3:0]);
            lo_vote    = vote();
            @(negedge clk);
            chk(wr_ready == 1'b0, "R4 busy2", {31'd0, wr_ready}, 32'd0);
            model[off+1] = enc(d[7:4]);
            @(negedge clk);
            chk(wr_ready == 1'b1, "R4 release", {31'd0, wr_ready}, 32'd1);
            chk(strap_word == lo_vote, "R7 lag", strap_word, lo_vote);
        end
    endtask

    task automatic check_strap(input string tag);
        @(negedge clk);
        chk(strap_word == vote(), tag, strap_word, vote());
    endtask

    task automatic check_rd(input int a, input string tag);
        rd_addr = a[9:0];
        @(negedge clk);
        chk(rd_data == model[a], tag, {24'd0, rd_data}, {24'd0, model[a]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        logic [31:0] boot_word;
        void'($urandom(32'd20240611));
        rst_n     = 1'b0;
        wr_valid  = 1'b0;
        wr_offset = '0;
        wr_data   = '0;
        rd_addr   = '0;
        for (int i = 0; i < AB; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(wr_ready == 1'b1, "R1 ready", {31'd0, wr_ready}, 32'd1);
        chk(wr_err == 1'b0, "R1 err", {31'd0, wr_err}, 32'd0);
        chk(strap_word == 32'd0, "R1 strap", strap_word, 32'd0);
        check_rd(0, "R1 byte0");
        check_rd(AB - 1, "R1 last byte");

        // R2 and R3: every nibble value, distinct low and high halves
        for (int n = 0; n < 16; n++) begin
            send(300 + 2 * n, {4'(15 - n), 4'(n)});
            check_rd(300 + 2 * n, "R2 low code");
            check_rd(301 + 2 * n, "R3 high code");
        end

        // R10: boot word stream at offset 64
        boot_word = 32'h5A3C96E1;
        for (int b = 0; b < 4; b++) send(64 + 2 * b, boot_word[8*b +: 8]);
        for (int a = 64; a < 72; a++) check_rd(a, "R10 boot word");

        // R5: last legal offset and the first illegal one
        send(AB - 1, 8'h77);
        check_rd(AB - 1, "R5 untouched");
        send(AB - 2, 8'hA5);
        check_rd(AB - 2, "R3 edge low");
        check_rd(AB - 1, "R3 edge high");

        // R6: fill all three copies, then disturb single copies
        for (int b = 0; b < 6; b++) send(2 * b, 8'(8'h3C + 8'(b * 37)));
        check_strap("R6 three copies");
        send(4, 8'hFF);
        send(6, 8'h00);
        check_strap("R6 one copy changed");
        send(3, 8'h96);
        check_strap("R6 straddling write");

        // R8: writes outside the copies leave the strap alone
        held = strap_word;
        send(500, 8'hC3);
        @(negedge clk);
        chk(strap_word == held, "R8 outside region", strap_word, held);

        // Seeded random mix, biased towards the strap region
        for (int it = 0; it < 400; it++) begin
            int off;
            logic [7:0] d;
            off = ($urandom % 3 == 0) ? int'($urandom % 12) : int'($urandom % AB);
            d   = 8'($urandom);
            send(off, d);
            check_strap("R6 random vote");
            check_rd(off, "R9 random low");
            if (off + 1 < AB) check_rd(off + 1, "R9 random high");
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule